// File: doc/BRIEF.md
# Paired Mealy and Moore State Machines

This block holds two four-state machines that run side by side. Both take the same serial bit `x_i` once per clock, qualified by `valid_i`, and both follow one shared next-state map. They differ only in how they form their one-bit outputs. The Mealy side decodes its output from the present state together with the live input bit. The Moore side decodes its output from the present state alone.

Each machine drives its current state code on a port for debug. Integrators use the pair to compare output timing: the Mealy output reacts to `x_i` within a cycle, while the Moore output only moves after a clock edge. Neither machine buffers its input, and neither has any purpose beyond its tables.

Top module: `fsm_pair`

## Requirements
- R1: While `rst_ni` is low, both state codes read 2'b00 (Q0), and both outputs read 0.
- R2: On a rising edge with `valid_i` high, each state moves as follows, using the codes Q0=00, Q1=01, Q2=10, Q3=11. From Q0 it goes to Q1 if x=0 and to Q2 if x=1. From Q1 it goes to Q2 if x=0 and to Q3 if x=1. From Q2 it goes to Q0 if x=0 and to Q3 if x=1. From Q3 it stays in Q3 if x=0 and goes to Q0 if x=1.
- R3: On a rising edge with `valid_i` low, both state codes keep their value, whatever `x_i` is.
- R4: With `valid_i` high, `mealy_o` is 1 exactly when the Mealy state is Q1 and x=1, or when the Mealy state is Q2 and x=0. Every other pair gives 0.
- R5: With `valid_i` low, `mealy_o` is 0.
- R6: `moore_o` is 1 exactly while the Moore state is Q1, and 0 in Q0, Q2 and Q3.
- R7: `moore_o` does not depend on `x_i` or on `valid_i` within a cycle. Toggling either input between edges leaves it unchanged.
- R8: `mealy_o` is combinational. When `x_i` changes between edges, `mealy_o` follows within the same cycle.
- R9: Because the two machines share their next-state map and their reset, the two state codes are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `x_i` for this cycle |
| x_i | input | 1 | Serial data bit |
| mealy_o | output | 1 | Mealy output, from state and input |
| moore_o | output | 1 | Moore output, from state alone |
| mealy_state_o | output | 2 | Mealy state code |
| moore_state_o | output | 2 | Moore state code |

## Verification
The bench builds the block with its default 2-bit state code, so only four states exist. With four states it can visit every state under every combination of `x_i` and `valid_i`, and check every cell of both tables directly. Within each visited cycle it also toggles `x_i` and `valid_i` before the edge, which exposes both the combinational Mealy path and the input-free Moore path. A long pseudo-random stream with idle gaps follows, compared every cycle against a table model inside the bench, and a reset applied in the middle of the stream confirms that both machines return to Q0 together.

// File: rtl/fsm_pair_pkg.sv
package fsm_pair_pkg;
  localparam int NUM_STATES = 4;
  localparam int STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_Q0 = 2'b00,
    ST_Q1 = 2'b01,
    ST_Q2 = 2'b10,
    ST_Q3 = 2'b11
  } fsm_state_e;
endpackage

// File: rtl/fsm_pair_step.sv
module fsm_pair_step
  import fsm_pair_pkg::*;
(
  input  fsm_state_e state_i,
  input  logic       x_i,
  output fsm_state_e next_o
);
  always_comb begin
    unique case (state_i)
      ST_Q0:   next_o = x_i ? ST_Q2 : ST_Q1;
      ST_Q1:   next_o = x_i ? ST_Q3 : ST_Q2;
      ST_Q2:   next_o = x_i ? ST_Q3 : ST_Q0;
      default: next_o = x_i ? ST_Q0 : ST_Q3;
    endcase
  end
endmodule

// File: rtl/fsm_pair_mealy_dec.sv
module fsm_pair_mealy_dec
  import fsm_pair_pkg::*;
(
  input  fsm_state_e state_i,
  input  logic       valid_i,
  input  logic       x_i,
  output logic       out_o
);
  logic hit;
  always_comb begin
    unique case (state_i)
      ST_Q1:   hit = x_i;
      ST_Q2:   hit = ~x_i;
      default: hit = 1'b0;
    endcase
  end
  assign out_o = valid_i & hit;
endmodule

// File: rtl/fsm_pair_moore_dec.sv
module fsm_pair_moore_dec
  import fsm_pair_pkg::*;
(
  input  fsm_state_e state_i,
  output logic       out_o
);
  assign out_o = (state_i == ST_Q1);
endmodule

// File: rtl/fsm_pair_core.sv
module fsm_pair_core
  import fsm_pair_pkg::*;
#(
  parameter bit IS_MOORE = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               x_i,
  output logic               out_o,
  output logic [STATE_W-1:0] state_o
);
  fsm_state_e state_q, state_d, step_next;

  fsm_pair_step i_step (
    .state_i (state_q),
    .x_i     (x_i),
    .next_o  (step_next)
  );

  assign state_d = valid_i ? step_next : state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_Q0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  generate
    if (IS_MOORE) begin : g_moore
      fsm_pair_moore_dec i_dec (
        .state_i (state_q),
        .out_o   (out_o)
      );
      // output may only rise after a qualified edge
      a_r6_moore_rise_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(out_o) |-> $past(valid_i));
    end else begin : g_mealy
      fsm_pair_mealy_dec i_dec (
        .state_i (state_q),
        .valid_i (valid_i),
        .x_i     (x_i),
        .out_o   (out_o)
      );
      a_r5_mealy_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> !out_o);
      a_r4_mealy_q0_q3_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_Q0 || state_q == ST_Q3) |-> !out_o);
    end
  endgenerate

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  a_r2_q3_stay_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !x_i && state_q == ST_Q3) |=> state_q == ST_Q3);
  a_r2_q0_always_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q == ST_Q0) |=> (state_q == ST_Q1 || state_q == ST_Q2));
  a_r2_q2_one_to_q3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && x_i && state_q == ST_Q2) |=> state_q == ST_Q3);
endmodule

// File: rtl/fsm_pair.sv
module fsm_pair
  import fsm_pair_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               x_i,
  output logic               mealy_o,
  output logic               moore_o,
  output logic [STATE_W-1:0] mealy_state_o,
  output logic [STATE_W-1:0] moore_state_o
);
  fsm_pair_core #(.IS_MOORE(1'b0)) i_mealy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x_i     (x_i),
    .out_o   (mealy_o),
    .state_o (mealy_state_o)
  );

  fsm_pair_core #(.IS_MOORE(1'b1)) i_moore (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x_i     (x_i),
    .out_o   (moore_o),
    .state_o (moore_state_o)
  );

  a_r9_states_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mealy_state_o == moore_state_o);
endmodule

// File: tb/test_fsm_pair.sv
module test_fsm_pair;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       x = 1'b0;
  logic       mealy, moore;
  logic [1:0] mealy_st, moore_st;

  int n_run = 0;
  int n_fail = 0;
  logic [1:0] model = 2'b00;

  fsm_pair i_fsm_pair (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .valid_i       (valid),
    .x_i           (x),
    .mealy_o       (mealy),
    .moore_o       (moore),
    .mealy_state_o (mealy_st),
    .moore_state_o (moore_st)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic b);
    case (s)
      2'd0: return b ? 2'd2 : 2'd1;
      2'd1: return b ? 2'd3 : 2'd2;
      2'd2: return b ? 2'd3 : 2'd0;
      default: return b ? 2'd0 : 2'd3;
    endcase
  endfunction

  function automatic logic ref_mealy(input logic [1:0] s, input logic v, input logic b);
    return v & ((s == 2'd1 & b) | (s == 2'd2 & ~b));
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2/R3 mealy state"}, {2'b0, mealy_st}, {2'b0, model});
    chk({tag, " R9 moore state"},    {2'b0, moore_st}, {2'b0, model});
    chk({tag, " R4/R5 mealy out"},   {3'b0, mealy}, {3'b0, ref_mealy(model, valid, x)});
    chk({tag, " R6 moore out"},      {3'b0, moore}, {3'b0, model == 2'd1});
  endtask

  // one cycle: drive at negedge, check, optionally wiggle inputs, then clock
  task automatic step(input logic v, input logic b, input bit wiggle);
    @(negedge clk);
    valid = v; x = b;
    #1 check_all("step");
    if (wiggle) begin
      logic m0;
      m0 = moore;
      x = ~b;
      #1;
      chk("R8 mealy follows x", {3'b0, mealy}, {3'b0, ref_mealy(model, v, ~b)});
      chk("R7 moore ignores x", {3'b0, moore}, {3'b0, m0});
      valid = ~v;
      #1;
      chk("R7 moore ignores valid", {3'b0, moore}, {3'b0, m0});
      chk("R5 mealy gated by valid", {3'b0, mealy}, {3'b0, ref_mealy(model, ~v, ~b)});
      valid = v; x = b;
      #1;
    end
    @(posedge clk);
    if (v) model = ref_next(model, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; x = 1'b0;
    #1;
    model = 2'b00;
    chk("R1 mealy state in reset", {2'b0, mealy_st}, 4'h0);
    chk("R1 moore state in reset", {2'b0, moore_st}, 4'h0);
    chk("R1 outputs in reset", {2'b0, mealy, moore}, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // near-exhaustive sweep: every state x every (valid, x)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset();
        case (s)
          1: step(1'b1, 1'b0, 1'b0);
          2: step(1'b1, 1'b1, 1'b0);
          3: begin step(1'b1, 1'b1, 1'b0); step(1'b1, 1'b1, 1'b0); end
          default: ;
        endcase
        step(c[1], c[0], 1'b1);
        // check the landing state (R2 when valid, R3 when idle)
        step(1'b0, 1'b0, 1'b0);
      end
    end
    // random stream with idle gaps and a mid-run reset
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) do_reset();
      step(($urandom % 4) != 0, $urandom % 2, (i % 7) == 0);
    end
    @(negedge clk);
    #1 check_all("final");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule